// File: doc/BRIEF.md
# Transmit Status and Operating-Mode Register Block

This block is the host-facing register file of a simple network controller. It holds a bank of four 32-bit transmit status words and an 8-bit operating-mode register. The transmit engine posts status words through a dedicated update port. The host reads them through a byte-addressed bus that carries an address, a read/write strobe and an access size of 1, 2 or 4 bytes. Sub-word reads are shifted down to bit 0 and masked to the access width. A read that is not aligned to its own size returns zero.

Bits 7:6 of the mode register pick one of four operating modes. Two outputs are decoded from that field. One enables writes to protected configuration registers elsewhere in the controller. The other marks normal operation, which is the only mode in which frames pass between host and network. An incoming frame offered while the mode is not normal is refused. Read data is registered and comes back one cycle after the read strobe.

Top module: `nic_txstat_regs`

## Requirements
- R1: While reset is asserted and after its release, the mode register reads 0x00, `net_normal` is 1, `cfg_wr_en` is 0, every status word reads 0 and `rd_valid` is 0.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `host_req`=1 and `host_we`=0, and 0 otherwise. `rd_data` holds the result of that read.
- R3: A 4-byte read (`host_size`=4) at status base + 4*k returns status word k whole. The default base is 0x10, so the four words sit at 0x10, 0x14, 0x18 and 0x1C.
- R4: A 2-byte read at byte offset 0 of a word returns bits 15:0 of that word. At byte offset 2 it returns bits 31:16. Both are zero-extended.
- R5: A 1-byte read at byte offset n (address bits 1:0 = n) returns bits 8n+7:8n of the word, zero-extended.
- R6: A status read whose address is not a multiple of its access size returns 0. This covers a 2-byte read at an odd address and a 4-byte read with address bits 1:0 not 00.
- R7: A status read with `host_size` other than 1, 2 or 4 returns 0.
- R8: An update-port write (`upd_valid`, `upd_idx`, `upd_data`) stores `upd_data` into word `upd_idx`. If a host write hits the same word in the same cycle, the update value wins. A host write to a different word in that cycle still lands.
- R9: A host write anywhere inside a status word's 4-byte range stores all 32 bits of `host_wdata` into that word, whatever `host_size` and address bits 1:0 are.
- R10: A host write to the mode address (default 0x50) loads `host_wdata[7:0]` into the mode register. Field bits 7:6 encode 00 = normal, 01 = autoload, 10 = programming, 11 = config-write. `cfg_wr_en` is 1 only when the field is 11.
- R11: `net_normal` is 1 only when the mode field is 00. `rx_frame_accept` equals `rx_frame_valid` in normal mode and is 0 in every other mode.
- R12: Bits 5:0 of the mode register read back as last written. A read of any size at the mode address returns the mode byte zero-extended.
- R13: A read at an address outside both the status range and the mode address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte address |
| host_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| host_wdata | input | 32 | Host write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read strobe |
| upd_valid | input | 1 | Transmit engine status update strobe |
| upd_idx | input | 2 | Status word index for the update |
| upd_data | input | 32 | Status value from the transmit engine |
| rx_frame_valid | input | 1 | An incoming frame is offered |
| rx_frame_accept | output | 1 | Offered frame is taken (normal mode only) |
| cfg_wr_en | output | 1 | Protected configuration registers writable |
| net_normal | output | 1 | Operating mode is normal |

## Verification
The status words are loaded with values whose four bytes all differ. A byte, half-word or word lane taken from the wrong place therefore shows up as a different value. Misaligned and illegal-size reads are aimed at words holding non-zero data, so a zero result can only come from rejection. Same-cycle host and update writes are tried once on one word and once on two different words, which separates the priority rule from plain loss of either write. The mode register is walked through all four field encodings with different low bits, so each decode output is seen both set and clear.

// File: rtl/nts_pkg.sv
package nts_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    OPM_NORMAL   = 2'b00,
    OPM_AUTOLOAD = 2'b01,
    OPM_PROGRAM  = 2'b10,
    OPM_CFGWRITE = 2'b11
  } opmode_e;

  function automatic logic size_is_legal(input logic [2:0] size);
    return (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  endfunction

  function automatic logic is_misaligned(input logic [1:0] lo, input logic [2:0] size);
    logic bad;
    bad = 1'b0;
    if (size == 3'd2) bad = lo[0];
    if (size == 3'd4) bad = (lo != 2'b00);
    return bad;
  endfunction

endpackage

// File: rtl/nts_mode_reg.sv
module nts_mode_reg
  import nts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] mode_byte,
  output logic       cfg_wr_en,
  output logic       net_normal
);

  logic [7:0] mode_q;
  logic [7:0] mode_d;
  opmode_e    field;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 8'h00;
    else if (wr_en) mode_q <= mode_d;
  end

  assign field      = opmode_e'(mode_q[7:6]);
  assign cfg_wr_en  = (field == OPM_CFGWRITE);
  assign net_normal = (field == OPM_NORMAL);
  assign mode_byte  = mode_q;

  assert_cfg_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_wr_en == ($past(wdata[7:6]) == 2'b11)));

  assert_normal_follows_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (net_normal == ($past(wdata[7:6]) == 2'b00)));

  assert_mode_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_byte == $past(wdata)));

  assert_mode_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_byte));

endmodule

// File: rtl/nts_status_bank.sv
module nts_status_bank
  import nts_pkg::*;
#(
  parameter int unsigned NUM_STAT = 4,
  parameter int unsigned IDX_W    = 2
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             host_wr,
  input  logic [IDX_W-1:0]                 host_idx,
  input  logic [WORD_W-1:0]                host_wdata,
  input  logic                             upd_valid,
  input  logic [IDX_W-1:0]                 upd_idx,
  input  logic [WORD_W-1:0]                upd_data,
  output logic [NUM_STAT-1:0][WORD_W-1:0]  words
);

  logic [NUM_STAT-1:0][WORD_W-1:0] words_q;

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_word
    logic              upd_hit;
    logic              host_hit;
    logic              load;
    logic [WORD_W-1:0] word_d;

    always_comb begin
      upd_hit  = upd_valid && (upd_idx == IDX_W'(g));
      host_hit = host_wr && (host_idx == IDX_W'(g));
      load     = upd_hit || host_hit;
      word_d   = words_q[g];
      if (upd_hit)       word_d = upd_data;
      else if (host_hit) word_d = host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words_q[g] <= '0;
      else if (load) words_q[g] <= word_d;
    end
  end

  assign words = words_q;

  assert_update_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (words_q[$past(upd_idx)] == $past(upd_data)));

  assert_host_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !(upd_valid && (upd_idx == host_idx)))
      |=> (words_q[$past(host_idx)] == $past(host_wdata)));

endmodule

// File: rtl/nts_read_path.sv
module nts_read_path
  import nts_pkg::*;
#(
  parameter int unsigned NUM_STAT = 4,
  parameter int unsigned IDX_W    = 2
)(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_req,
  input  logic                            in_stat,
  input  logic                            in_mode,
  input  logic [IDX_W-1:0]                idx,
  input  logic [1:0]                      byte_off,
  input  logic [2:0]                      size,
  input  logic [NUM_STAT-1:0][WORD_W-1:0] words,
  input  logic [7:0]                      mode_byte,
  output logic [WORD_W-1:0]               rd_data,
  output logic                            rd_valid
);

  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] sel_data;
  logic              stat_ok;
  logic [WORD_W-1:0] rd_data_q, rd_data_d;
  logic              rd_valid_q, rd_valid_d;

  always_comb begin
    sel_word = words[idx];
    shifted  = sel_word >> {byte_off, 3'b000};
    stat_ok  = in_stat && size_is_legal(size) && !is_misaligned(byte_off, size);
    sel_data = '0;
    if (in_mode) begin
      sel_data = {{(WORD_W-8){1'b0}}, mode_byte};
    end else if (stat_ok) begin
      case (size)
        3'd1:    sel_data = {{(WORD_W-BYTE_W){1'b0}}, shifted[BYTE_W-1:0]};
        3'd2:    sel_data = {{(WORD_W-2*BYTE_W){1'b0}}, shifted[2*BYTE_W-1:0]};
        default: sel_data = shifted;
      endcase
    end
  end

  always_comb begin
    rd_data_d  = rd_data_q;
    if (rd_req) rd_data_d = sel_data;
    rd_valid_d = rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      if (rd_req) rd_data_q <= rd_data_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  assert_rdvalid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_no_spurious_rdvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  assert_misaligned_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && in_stat && (size == 3'd2) && byte_off[0]) |=> (rd_data == '0));

  assert_bad_size_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && in_stat && (size != 3'd1) && (size != 3'd2) && (size != 3'd4))
      |=> (rd_data == '0));

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !in_stat && !in_mode) |=> (rd_data == '0));

endmodule

// File: rtl/nic_txstat_regs.sv
module nic_txstat_regs
  import nts_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_STAT  = 4,
  parameter int unsigned STAT_BASE = 'h10,
  parameter int unsigned MODE_ADDR = 'h50,
  localparam int unsigned IDX_W    = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [2:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [31:0]       upd_data,
  input  logic              rx_frame_valid,
  output logic              rx_frame_accept,
  output logic              cfg_wr_en,
  output logic              net_normal
);

  localparam logic [ADDR_W:0]   STAT_LO = (ADDR_W+1)'(STAT_BASE);
  localparam logic [ADDR_W:0]   STAT_HI = (ADDR_W+1)'(STAT_BASE + 4*NUM_STAT);
  localparam logic [ADDR_W-1:0] MODE_A  = ADDR_W'(MODE_ADDR);

  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic                            in_stat, in_mode;
  logic [ADDR_W-1:0]               stat_off;
  logic [IDX_W-1:0]                idx;
  logic                            rd_req, stat_wr, mode_wr;
  logic [NUM_STAT-1:0][WORD_W-1:0] words;
  logic [7:0]                      mode_byte;
  logic                            unused_ok;

  always_comb begin
    in_stat  = ({1'b0, host_addr} >= STAT_LO) && ({1'b0, host_addr} < STAT_HI);
    in_mode  = (host_addr == MODE_A);
    stat_off = host_addr - ADDR_W'(STAT_BASE);
    idx      = stat_off[IDX_W+1:2];
    rd_req   = host_req && !host_we;
    stat_wr  = host_req && host_we && in_stat;
    mode_wr  = host_req && host_we && in_mode;
  end

  assign unused_ok = ^{stat_off, host_wdata[31:8]};

  nts_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (mode_wr),
    .wdata      (host_wdata[7:0]),
    .mode_byte  (mode_byte),
    .cfg_wr_en  (cfg_wr_en),
    .net_normal (net_normal)
  );

  nts_status_bank #(.NUM_STAT(NUM_STAT), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_wr    (stat_wr),
    .host_idx   (idx),
    .host_wdata (host_wdata),
    .upd_valid  (upd_valid),
    .upd_idx    (upd_idx),
    .upd_data   (upd_data),
    .words      (words)
  );

  nts_read_path #(.NUM_STAT(NUM_STAT), .IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_req    (rd_req),
    .in_stat   (in_stat),
    .in_mode   (in_mode),
    .idx       (idx),
    .byte_off  (host_addr[1:0]),
    .size      (host_size),
    .words     (words),
    .mode_byte (mode_byte),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign rx_frame_accept = rx_frame_valid && net_normal;

  assert_frame_dropped_off_normal_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_byte[7:6] != 2'b00) |-> !rx_frame_accept);

  assert_cfg_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cfg_wr_en && net_normal));

endmodule

// File: tb/nic_txstat_regs_bench.sv
module nic_txstat_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [7:0]  host_addr;
  logic [2:0]  host_size;
  logic [31:0] host_wdata;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        upd_valid;
  logic [1:0]  upd_idx;
  logic [31:0] upd_data;
  logic        rx_frame_valid, rx_frame_accept, cfg_wr_en, net_normal;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_txstat_regs u_nic_txstat_regs (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .upd_valid(upd_valid),
    .upd_idx(upd_idx), .upd_data(upd_data), .rx_frame_valid(rx_frame_valid),
    .rx_frame_accept(rx_frame_accept), .cfg_wr_en(cfg_wr_en), .net_normal(net_normal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when the design reports a read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected rd_valid", 32'd1, 32'd0);
      else check(rd_data == exp_q[0], tag_q[0], rd_data, exp_q[0]);
      if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] exp, input string tag);
    host_req = 1'b1; host_we = 1'b0; host_addr = a; host_size = sz;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_size = sz; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic do_update(input logic [1:0] i, input logic [31:0] d);
    upd_valid = 1'b1; upd_idx = i; upd_data = d;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic both_write(input logic [7:0] a, input logic [31:0] hd, input logic [1:0] i, input logic [31:0] ud);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_size = 3'd4; host_wdata = hd;
    upd_valid = 1'b1; upd_idx = i; upd_data = ud;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; upd_valid = 1'b0;
  endtask

  task automatic check_mode(input logic cfg_exp, input logic norm_exp, input string tag);
    rx_frame_valid = 1'b1;
    #1;
    check(cfg_wr_en == cfg_exp, {tag, " R10 cfg_wr_en"}, 32'(cfg_wr_en), 32'(cfg_exp));
    check(net_normal == norm_exp, {tag, " R11 net_normal"}, 32'(net_normal), 32'(norm_exp));
    check(rx_frame_accept == norm_exp, {tag, " R11 rx_frame_accept"}, 32'(rx_frame_accept), 32'(norm_exp));
    rx_frame_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    checks++; failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_size = 3'd4;
    host_wdata = '0; upd_valid = 1'b0; upd_idx = '0; upd_data = '0; rx_frame_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1: values held during reset
    check(rd_valid == 1'b0, "R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    check(cfg_wr_en == 1'b0, "R1 cfg_wr_en in reset", 32'(cfg_wr_en), 32'd0);
    check(net_normal == 1'b1, "R1 net_normal in reset", 32'(net_normal), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_mode(1'b0, 1'b1, "R1 after reset");
    do_read(8'h10, 3'd4, 32'h0, "R1 word0 after reset");
    do_read(8'h1C, 3'd4, 32'h0, "R1 word3 after reset");
    do_read(8'h50, 3'd1, 32'h0, "R1 mode after reset");

    // R3 R9: host word write then reads
    do_write(8'h10, 3'd4, 32'hA1B2C3D4);
    check(rd_valid == 1'b0, "R2 no rd_valid after write", 32'(rd_valid), 32'd0);
    do_read(8'h10, 3'd4, 32'hA1B2C3D4, "R3 word0");
    // R5 byte lanes
    do_read(8'h10, 3'd1, 32'h000000D4, "R5 byte0");
    do_read(8'h11, 3'd1, 32'h000000C3, "R5 byte1");
    do_read(8'h12, 3'd1, 32'h000000B2, "R5 byte2");
    do_read(8'h13, 3'd1, 32'h000000A1, "R5 byte3");
    // R4 halves
    do_read(8'h10, 3'd2, 32'h0000C3D4, "R4 half low");
    do_read(8'h12, 3'd2, 32'h0000A1B2, "R4 half high");
    // R6 misaligned
    do_read(8'h11, 3'd2, 32'h0, "R6 half at odd");
    do_read(8'h13, 3'd2, 32'h0, "R6 half at 3");
    do_read(8'h12, 3'd4, 32'h0, "R6 word at 2");
    do_read(8'h11, 3'd4, 32'h0, "R6 word at 1");
    // R7 illegal sizes
    do_read(8'h10, 3'd3, 32'h0, "R7 size 3");
    do_read(8'h10, 3'd0, 32'h0, "R7 size 0");
    do_read(8'h10, 3'd7, 32'h0, "R7 size 7");
    // R9: write at non-aligned address and size stores full word
    do_write(8'h15, 3'd1, 32'h12345678);
    do_read(8'h14, 3'd4, 32'h12345678, "R9 full word via byte write");
    // R8 update port
    do_update(2'd2, 32'h11223344);
    do_read(8'h18, 3'd4, 32'h11223344, "R8 update word2");
    do_read(8'h1B, 3'd1, 32'h00000011, "R8 R5 update byte3");
    both_write(8'h1C, 32'hDEAD0000, 2'd3, 32'h55667788);
    do_read(8'h1C, 3'd4, 32'h55667788, "R8 update wins same word");
    both_write(8'h14, 32'h0BADF00D, 2'd0, 32'hCAFEBABE);
    do_read(8'h14, 3'd4, 32'h0BADF00D, "R8 host write other word lands");
    do_read(8'h10, 3'd4, 32'hCAFEBABE, "R8 update other word lands");
    // R13 unmapped
    do_read(8'h30, 3'd4, 32'h0, "R13 unmapped 0x30");
    do_read(8'h20, 3'd4, 32'h0, "R13 just past status");
    do_read(8'h0C, 3'd4, 32'h0, "R13 just below status");

    // R10 R11 R12 mode walk
    do_write(8'h50, 3'd1, 32'h000000C5);
    check_mode(1'b1, 1'b0, "cfgwrite");
    do_read(8'h50, 3'd1, 32'h000000C5, "R12 readback C5");
    do_write(8'h50, 3'd1, 32'h0000006A);
    check_mode(1'b0, 1'b0, "autoload");
    do_read(8'h50, 3'd4, 32'h0000006A, "R12 readback 6A word");
    do_write(8'h50, 3'd1, 32'h00000080);
    check_mode(1'b0, 1'b0, "programming");
    do_read(8'h50, 3'd2, 32'h00000080, "R12 readback 80 half");
    do_write(8'h50, 3'd1, 32'hFFFFFF3F);
    check_mode(1'b0, 1'b1, "normal");
    do_read(8'h50, 3'd1, 32'h0000003F, "R12 readback 3F");
    // status untouched by mode writes
    do_read(8'h18, 3'd4, 32'h11223344, "R8 word2 kept");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule